// File: doc/BRIEF.md
# Type 1 Configuration Forwarding Decoder

This block belongs to a two-port bridge between a host-side bus and a device-side bus. It looks at every configuration transaction during its address phase and makes one of three decisions. It can pass the transaction to the other bus as an unchanged Type 1 request. It can turn a configuration write into a special cycle on the other bus. Or it can leave the transaction where it is. The direction input tells it whether the request came from the host side (downstream) or from the device side (upstream).

The decision, the command code for the outgoing bus and a flag are registered together. The flag tells the bus engine to stop after one data transfer. All three are taken on the clock edge that ends the address phase and are held until the transaction finishes. The bus-number registers of the bridge are sampled as plain inputs. The address/data word is taken apart into fixed fields:
- bus number in bits 23:16
- device in bits 15:11
- function in bits 10:8
- register in bits 7:2
- type code in bits 1:0

Top module: `t1fwd_decoder`

## Requirements
- R1: A transaction can give a non-zero decision only when ad[1:0] equals 01b. With any other value, the decision is none (00b).
- R2: Downstream (dir_up=0), a configuration read (cbe=1010b) or write (cbe=1011b) is forwarded as Type 1 (decision 01b) when its bus number is strictly above sec_bus and at most sub_bus. A bus number equal to sec_bus is not forwarded as Type 1.
- R3: Upstream (dir_up=1), a transaction is forwarded as Type 1 only when all four of these hold: the command is a configuration write (1011b), the bus number is below sec_bus or above sub_bus, the device field is 11111b, and the function field is 111b.
- R4: When the decision is Type 1, out_cmd equals the command sampled in the address phase.
- R5: A configuration write gives decision 10b with out_cmd 0001b when all of these hold: ad[1:0] is 01b, device is 11111b, function is 111b, and register is 000000b. The bus number must also equal sec_bus downstream, or pri_bus upstream.
- R6: When a transaction meets both the special-cycle rule and the Type 1 rule, the special-cycle result wins.
- R7: An incoming special cycle (cbe=0001b) and any command other than a configuration read or write give decision none.
- R8: single_xfer is 1 exactly when the decision is Type 1 and the forwarded command is a configuration write. It is 0 otherwise.
- R9: The outputs change on the rising edge at which addr_phase is 1. They then hold until an edge with txn_end=1, which sets them to none, 0000b and 0. If addr_phase and txn_end are both 1, addr_phase wins.
- R10: While rst_n is low, the outputs are decision 00b, out_cmd 0000b and single_xfer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr_phase | input | 1 | High in the address-phase cycle of a transaction |
| txn_end | input | 1 | High in the final cycle of the transaction |
| dir_up | input | 1 | 0 when the request comes from the host side, 1 when it comes from the device side |
| ad | input | 32 | Address/data word sampled in the address phase |
| cbe | input | 4 | Bus command nibble |
| pri_bus | input | 8 | Primary bus number register |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| decision | output | 2 | 00 none, 01 Type 1 forward, 10 special cycle |
| out_cmd | output | 4 | Command to drive on the target bus |
| single_xfer | output | 1 | Limit the forwarded transfer to one data phase |

## Verification
All state sits in one register bank. A wrong capture therefore shows up on decision, out_cmd or single_xfer one edge after the address phase, and it stays wrong until the transaction ends. The bench models each decision one cycle ahead and compares on every clock, so a bad boundary compare or a bad priority shows up in the cycle right after the transaction that exposes it. A fault in holding or clearing shows up in the first idle cycle or at the first txn_end.

// File: rtl/t1fwd_pkg.sv
package t1fwd_pkg;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam int BUS_W  = 8;

    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int DEV_W   = 5;
    localparam int FN_LSB  = 8;
    localparam int FN_W    = 3;
    localparam int REG_LSB = 2;
    localparam int REG_W   = 6;

    localparam logic [CMD_W-1:0] CMD_NONE   = 4'b0000;
    localparam logic [CMD_W-1:0] CMD_SPC    = 4'b0001;
    localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;
    localparam logic [1:0]       TYPE1_CODE = 2'b01;
    localparam logic [REG_W-1:0] SPC_REG    = '0;

    typedef enum logic [1:0] {
        DEC_NONE  = 2'b00,
        DEC_TYPE1 = 2'b01,
        DEC_SPC   = 2'b10
    } dec_e;

    typedef struct packed {
        dec_e             dec;
        logic [CMD_W-1:0] cmd;
        logic             single;
    } fwd_state_t;
endpackage

// File: rtl/t1fwd_range_chk.sv
module t1fwd_range_chk #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] lo,
    input  logic [BUS_W-1:0] hi,
    output logic             in_open_lo,
    output logic             out_closed
);
    logic above_lo;
    logic at_lo;
    logic not_above_hi;

    always_comb begin
        above_lo     = bus > lo;
        at_lo        = bus == lo;
        not_above_hi = bus <= hi;
        // downstream window excludes the lower limit
        in_open_lo   = above_lo && not_above_hi;
        // upstream test is outside a window that includes both limits
        out_closed   = !((above_lo || at_lo) && not_above_hi);
    end
endmodule

// File: rtl/t1fwd_match.sv
module t1fwd_match
    import t1fwd_pkg::*;
(
    input  logic              dir_up,
    input  logic [ADDR_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              hit_type1,
    output logic              hit_spc,
    output logic              is_wr
);
    logic [BUS_W-1:0] f_bus;
    logic [DEV_W-1:0] f_dev;
    logic [FN_W-1:0]  f_fn;
    logic [REG_W-1:0] f_reg;
    logic             type_ok;
    logic             is_rd;
    logic             all_ones_id;
    logic             in_open_lo;
    logic             out_closed;
    logic             bus_hits_own;

    always_comb begin
        f_bus   = ad[BUS_LSB +: BUS_W];
        f_dev   = ad[DEV_LSB +: DEV_W];
        f_fn    = ad[FN_LSB  +: FN_W];
        f_reg   = ad[REG_LSB +: REG_W];
        type_ok = ad[1:0] == TYPE1_CODE;
    end

    t1fwd_range_chk #(.BUS_W(BUS_W)) u_range (
        .bus        (f_bus),
        .lo         (sec_bus),
        .hi         (sub_bus),
        .in_open_lo (in_open_lo),
        .out_closed (out_closed)
    );

    always_comb begin
        is_rd        = cbe == CMD_CFG_RD;
        is_wr        = cbe == CMD_CFG_WR;
        all_ones_id  = (&f_dev) && (&f_fn);
        bus_hits_own = dir_up ? (f_bus == pri_bus) : (f_bus == sec_bus);
        hit_spc      = type_ok && is_wr && all_ones_id &&
                       (f_reg == SPC_REG) && bus_hits_own;
        if (dir_up) begin
            hit_type1 = type_ok && is_wr && out_closed && all_ones_id;
        end else begin
            hit_type1 = type_ok && (is_rd || is_wr) && in_open_lo;
        end
    end
endmodule

// File: rtl/t1fwd_decoder.sv
module t1fwd_decoder
    import t1fwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_phase,
    input  logic        txn_end,
    input  logic        dir_up,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe,
    input  logic [7:0]  pri_bus,
    input  logic [7:0]  sec_bus,
    input  logic [7:0]  sub_bus,
    output logic [1:0]  decision,
    output logic [3:0]  out_cmd,
    output logic        single_xfer
);
    logic       hit_type1;
    logic       hit_spc;
    logic       is_wr;
    fwd_state_t st_d;
    fwd_state_t st_q;

    t1fwd_match u_match (
        .dir_up    (dir_up),
        .ad        (ad),
        .cbe       (cbe),
        .pri_bus   (pri_bus),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .hit_type1 (hit_type1),
        .hit_spc   (hit_spc),
        .is_wr     (is_wr)
    );

    always_comb begin
        st_d = st_q;
        if (addr_phase) begin
            if (hit_spc) begin
                st_d.dec    = DEC_SPC;
                st_d.cmd    = CMD_SPC;
                st_d.single = 1'b0;
            end else if (hit_type1) begin
                st_d.dec    = DEC_TYPE1;
                st_d.cmd    = cbe;
                st_d.single = is_wr;
            end else begin
                st_d.dec    = DEC_NONE;
                st_d.cmd    = CMD_NONE;
                st_d.single = 1'b0;
            end
        end else if (txn_end) begin
            st_d.dec    = DEC_NONE;
            st_d.cmd    = CMD_NONE;
            st_d.single = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dec    <= DEC_NONE;
            st_q.cmd    <= CMD_NONE;
            st_q.single <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision    = st_q.dec;
    assign out_cmd     = st_q.cmd;
    assign single_xfer = st_q.single;
endmodule

// File: rtl/t1fwd_decoder_chk.sv
module t1fwd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_phase,
    input logic        txn_end,
    input logic        dir_up,
    input logic [31:0] ad,
    input logic [3:0]  cbe,
    input logic [1:0]  decision,
    input logic [3:0]  out_cmd,
    input logic        single_xfer
);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase && !txn_end) |=> ($stable(decision) && $stable(out_cmd) && $stable(single_xfer)));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && !addr_phase) |=> (decision == 2'b00 && out_cmd == 4'b0000 && !single_xfer));

    a_r1_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && ad[1:0] != 2'b01) |=> decision == 2'b00);

    a_r5_spc_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (decision == 2'b10) |-> (out_cmd == 4'b0001 && !single_xfer));

    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        decision != 2'b11);

    a_r4_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && ad[1:0] == 2'b01) |=> (decision != 2'b01 || out_cmd == $past(cbe)));

    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        single_xfer |-> (decision == 2'b01 && out_cmd == 4'b1011));

    a_r7_spc_in: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && cbe == 4'b0001) |=> decision == 2'b00);

    a_r3_up_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && dir_up && cbe != 4'b1011) |=> decision == 2'b00);
endmodule

bind t1fwd_decoder t1fwd_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_phase  (addr_phase),
    .txn_end     (txn_end),
    .dir_up      (dir_up),
    .ad          (ad),
    .cbe         (cbe),
    .decision    (decision),
    .out_cmd     (out_cmd),
    .single_xfer (single_xfer)
);

// File: tb/t1fwd_decoder_test.sv
module t1fwd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0;
    logic        txn_end = 1'b0;
    logic        dir_up = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic [7:0]  pri_bus = 8'd1;
    logic [7:0]  sec_bus = 8'd2;
    logic [7:0]  sub_bus = 8'd5;
    logic [1:0]  decision;
    logic [3:0]  out_cmd;
    logic        single_xfer;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R10";

    logic [1:0] e_dec = 2'b00;
    logic [3:0] e_cmd = 4'b0000;
    logic       e_one = 1'b0;

    always #2 clk = ~clk;

    t1fwd_decoder uut (
        .clk (clk), .rst_n (rst_n), .addr_phase (addr_phase), .txn_end (txn_end),
        .dir_up (dir_up), .ad (ad), .cbe (cbe), .pri_bus (pri_bus),
        .sec_bus (sec_bus), .sub_bus (sub_bus), .decision (decision),
        .out_cmd (out_cmd), .single_xfer (single_xfer)
    );

    function automatic logic [6:0] ref_decide(input logic up, input logic [31:0] a,
        input logic [3:0] c, input int pb, input int sb, input int ub);
        int  bus;
        bit  rd, wr, ids, spc, t1;
        bus = int'(a[23:16]);
        rd  = (c == 4'b1010);
        wr  = (c == 4'b1011);
        ids = (a[15:11] == 5'b11111) && (a[10:8] == 3'b111);
        spc = 0;
        t1  = 0;
        if (a[1:0] == 2'b01) begin
            if (wr && ids && a[7:2] == 6'd0 && bus == (up ? pb : sb)) spc = 1;
            if (!up && (rd || wr) && bus > sb && bus <= ub) t1 = 1;
            if (up && wr && ids && (bus < sb || bus > ub)) t1 = 1;
        end
        if (spc) return {2'b10, 4'b0001, 1'b0};
        if (t1)  return {2'b01, c, wr};
        return 7'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_dec <= 2'b00; e_cmd <= 4'b0000; e_one <= 1'b0;
        end else if (addr_phase) begin
            {e_dec, e_cmd, e_one} <= ref_decide(dir_up, ad, cbe,
                int'(pri_bus), int'(sec_bus), int'(sub_bus));
        end else if (txn_end) begin
            e_dec <= 2'b00; e_cmd <= 4'b0000; e_one <= 1'b0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            total++;
            if (decision !== e_dec || out_cmd !== e_cmd || single_xfer !== e_one) begin
                bad++;
                $display("FAIL %s: got dec=%b cmd=%b one=%b expected dec=%b cmd=%b one=%b",
                         tag, decision, out_cmd, single_xfer, e_dec, e_cmd, e_one);
            end
        end
    end

    function automatic logic [31:0] mk(input int bus, input int dev, input int fn,
                                       input int rg, input int ty);
        return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'(ty)};
    endfunction

    task automatic txn(input string t, input logic up, input logic [31:0] a,
                       input logic [3:0] c);
        @(negedge clk);
        tag = t; dir_up = up; ad = a; cbe = c; addr_phase = 1'b1; txn_end = 1'b0;
        @(negedge clk);
        addr_phase = 1'b0; ad = ~a; cbe = 4'b0110;
        @(negedge clk);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2, R4, R8: downstream read and write inside the window
        txn("R2", 1'b0, mk(3, 0, 0, 4, 1), 4'b1010);
        txn("R8", 1'b0, mk(5, 0, 0, 4, 1), 4'b1011);
        // R2: lower limit is excluded, above sub is rejected
        txn("R2", 1'b0, mk(2, 3, 1, 4, 1), 4'b1011);
        txn("R2", 1'b0, mk(6, 0, 0, 4, 1), 4'b1010);
        // R1: wrong type code
        txn("R1", 1'b0, mk(3, 0, 0, 4, 0), 4'b1010);
        txn("R1", 1'b0, mk(3, 0, 0, 4, 3), 4'b1011);
        // R5: downstream special cycle and near misses
        txn("R5", 1'b0, mk(2, 31, 7, 0, 1), 4'b1011);
        txn("R5", 1'b0, mk(2, 31, 7, 1, 1), 4'b1011);
        txn("R5", 1'b0, mk(2, 31, 6, 0, 1), 4'b1011);
        // R3: upstream rules
        txn("R3", 1'b1, mk(7, 31, 7, 4, 1), 4'b1011);
        txn("R3", 1'b1, mk(7, 31, 7, 4, 1), 4'b1010);
        txn("R3", 1'b1, mk(3, 31, 7, 4, 1), 4'b1011);
        txn("R3", 1'b1, mk(2, 31, 7, 4, 1), 4'b1011);
        txn("R3", 1'b1, mk(9, 30, 7, 4, 1), 4'b1011);
        // R6: upstream special overlaps Type 1 (bus 1 below sec)
        txn("R6", 1'b1, mk(1, 31, 7, 0, 1), 4'b1011);
        txn("R3", 1'b1, mk(1, 31, 7, 5, 1), 4'b1011);
        // R7: incoming special cycle and other commands
        txn("R7", 1'b0, mk(3, 31, 7, 0, 1), 4'b0001);
        txn("R7", 1'b1, mk(1, 31, 7, 0, 1), 4'b0001);
        txn("R7", 1'b0, mk(4, 0, 0, 0, 1), 4'b0110);
        // R9: long hold, then addr_phase winning over txn_end
        @(negedge clk);
        tag = "R9"; dir_up = 1'b0; ad = mk(4, 0, 0, 2, 1); cbe = 4'b1011; addr_phase = 1'b1;
        @(negedge clk);
        addr_phase = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ad = mk(i, 31, 7, 0, 1); cbe = 4'b1010;
            @(negedge clk);
        end
        ad = mk(3, 0, 0, 0, 1); addr_phase = 1'b1; txn_end = 1'b1;
        @(negedge clk);
        addr_phase = 1'b0; txn_end = 1'b0;
        @(negedge clk);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        // R10: reset in the middle of a held decision
        txn("R10", 1'b0, mk(4, 0, 0, 0, 1), 4'b1011);
        @(negedge clk);
        tag = "R10"; addr_phase = 1'b1; ad = mk(3, 0, 0, 0, 1); cbe = 4'b1011;
        @(negedge clk);
        addr_phase = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // mixed patterns against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            tag = "R2/R3/R5 mix";
            dir_up     = $urandom_range(0, 1);
            addr_phase = ($urandom_range(0, 2) == 0);
            txn_end    = ($urandom_range(0, 3) == 0);
            ad = mk($urandom_range(0, 8), ($urandom_range(0, 1) != 0) ? 31 : $urandom_range(0, 31),
                    ($urandom_range(0, 1) != 0) ? 7 : $urandom_range(0, 7),
                    ($urandom_range(0, 1) != 0) ? 0 : $urandom_range(0, 63),
                    ($urandom_range(0, 3) != 0) ? 1 : $urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: cbe = 4'b1010;
                1: cbe = 4'b1011;
                2: cbe = 4'b0001;
                default: cbe = 4'($urandom_range(0, 15));
            endcase
            if (i % 97 == 0) begin
                pri_bus = 8'($urandom_range(0, 3));
                sec_bus = 8'($urandom_range(1, 4));
                sub_bus = 8'($urandom_range(4, 7));
            end
        end
        @(negedge clk);
        addr_phase = 1'b0; txn_end = 1'b0;
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule